// File: doc/BRIEF.md
# Single-error-correcting, double-error-detecting memory word protector

This block guards a 32-bit memory word with a 7-bit check field and checks the 39-bit word that comes back from memory. Before a write, the host sets the mode to write, presents the data and stores the returned check field next to it. On a read, the host first runs a flag pass. That pass captures the raw word into internal holding registers and reports whether any error is present. The host then runs a correct pass, which works only from the held copy and returns the repaired data together with the syndrome. The syndrome points at the failing bit.

A diagnostic mode returns the held data and check bits unchanged. Software can compare them against memory to decide whether a fault lies in the storage or in this logic. A check-bit-only fault is reported, but the data passes through untouched. Two-bit faults and the stuck-at-all-zeros or stuck-at-all-ones word are reported as uncorrectable.

All outputs are registered. Each result appears one clock after the mode and inputs that produced it.

Top module: `secded_edac`

## Requirements
- R1: Column j of the code is the j-th smallest 7-bit value with exactly three ones, so column 0 is 0000111 and column 31 is 1100010. Check bit i is the XOR of every data bit j whose column has bit i set, XORed with bit i of the inversion mask 0000011. Check bits 0 and 1 therefore use inverted parity.
- R2: With mode_i = 00 (write), one clock later chk_o holds the check field of data_i, data_o equals data_i, and both flags are low.
- R3: The syndrome is the check field recomputed from the data XOR the received check field. It appears on chk_o in mode 10 (flag) and mode 11 (correct). In flag mode, data_o shows the raw input data.
- R4: A single flipped data bit j gives syndrome = column j, with sgl_err_o high and mul_err_o low. In mode 11, data_o is the held data with bit j inverted.
- R5: A single flipped check bit k gives a one-hot syndrome with bit k set, with sgl_err_o high and mul_err_o low. In mode 11, data_o equals the held data unchanged.
- R6: Any two flipped bits among the 39 raise both sgl_err_o and mul_err_o, and data_o in mode 11 is the held data unchanged. Any other nonzero syndrome that is neither a column nor one-hot is handled the same way.
- R7: A 39-bit word of all zeros or all ones raises both flags.
- R8: An error-free word gives syndrome 0 and both flags low. In mode 11, the held data is returned.
- R9: The holding registers load data_i and chk_i on every clock edge with mode 10 and keep their value in all other modes. Mode 11 ignores data_i and chk_i.
- R10: With mode_i = 01 (diagnostic), one clock later data_o and chk_o show the holding registers and both flags are low.
- R11: During reset, every output and both holding registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 write, 01 diagnostic, 10 flag, 11 correct |
| data_i | input | 32 | Data word from the host or from memory |
| chk_i | input | 7 | Check field from memory |
| data_o | output | 32 | Pass-through, corrected or held data |
| chk_o | output | 7 | Generated check field, syndrome or held check bits |
| sgl_err_o | output | 1 | Any error detected |
| mul_err_o | output | 1 | Uncorrectable error detected |

## Verification
Every mode produces its result exactly one clock edge after the mode and inputs are applied. Correction and diagnostic results come from the copy that was captured at the edge of the previous flag pass. The bench changes inputs on the falling edge and compares the outputs on the next falling edge, which is half a period after the edge that registered them. It feeds junk on data_i and chk_i during the correct pass, so the check also shows those inputs are ignored.

// File: rtl/edac_pkg.sv
package edac_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_DIAG  = 2'b01,
    MODE_FLAG  = 2'b10,
    MODE_CORR  = 2'b11
  } edac_mode_e;

  // j-th smallest value of cw bits with exactly three ones
  function automatic logic [15:0] col_of(input int unsigned j, input int unsigned cw);
    int unsigned n;
    logic [15:0] r;
    n = 0;
    r = '0;
    for (int unsigned v = 1; v < (32'd1 << cw); v++) begin
      if ($countones(v) == 3) begin
        if (n == j) r = v[15:0];
        n++;
      end
    end
    return r;
  endfunction

  // data bits feeding check bit i
  function automatic logic [63:0] row_of(input int unsigned i, input int unsigned dw,
                                         input int unsigned cw);
    logic [63:0] r;
    logic [15:0] c;
    r = '0;
    for (int unsigned j = 0; j < dw; j++) begin
      c = col_of(j, cw);
      r[j] = c[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/edac_chk_gen.sv
module edac_chk_gen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHK_W  = 7,
  parameter logic [CHK_W-1:0] CHK_INV = 7'b0000011
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  for (genvar i = 0; i < CHK_W; i++) begin : g_bit
    localparam logic [63:0] ROW = edac_pkg::row_of(i, DATA_W, CHK_W);
    assign chk_o[i] = (^(data_i & ROW[DATA_W-1:0])) ^ CHK_INV[i];
  end
endmodule

// File: rtl/edac_syn_dec.sv
module edac_syn_dec #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHK_W  = 7
) (
  input  logic [CHK_W-1:0]  syn_i,
  input  logic              gross_i,
  output logic [DATA_W-1:0] flip_o,
  output logic              sgl_o,
  output logic              mul_o
);
  logic [DATA_W-1:0] hit;
  logic nz, odd_w, chk_only, unmatched;

  for (genvar j = 0; j < DATA_W; j++) begin : g_col
    localparam logic [15:0] COL = edac_pkg::col_of(j, CHK_W);
    assign hit[j] = (syn_i == COL[CHK_W-1:0]);
  end

  assign nz        = |syn_i;
  assign odd_w     = ^syn_i;
  assign chk_only  = $onehot(syn_i);
  assign unmatched = odd_w & ~(|hit) & ~chk_only;

  assign sgl_o  = nz | gross_i;
  assign mul_o  = gross_i | (nz & ~odd_w) | unmatched;
  assign flip_o = mul_o ? '0 : hit;
endmodule

// File: rtl/edac_in_latch.sv
module edac_in_latch #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHK_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  chk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      chk_o  <= '0;
    end else if (load_i) begin
      data_o <= data_i;
      chk_o  <= chk_i;
    end
  end

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(data_o) && $stable(chk_o)));
  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (data_o == $past(data_i) && chk_o == $past(chk_i)));
endmodule

// File: rtl/secded_edac.sv
module secded_edac #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHK_W  = 7,
  parameter logic [CHK_W-1:0] CHK_INV = 7'b0000011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  chk_o,
  output logic              sgl_err_o,
  output logic              mul_err_o
);
  import edac_pkg::*;

  localparam int unsigned WORD_W = DATA_W + CHK_W;

  logic [DATA_W-1:0] lat_d, src_d, flip, d_nx;
  logic [CHK_W-1:0]  lat_c, src_c, gen_c, syn, c_nx;
  logic [WORD_W-1:0] word;
  logic              gross, sgl, mul, s_nx, m_nx, use_lat;

  edac_in_latch #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(mode_i == MODE_FLAG),
    .data_i(data_i),
    .chk_i (chk_i),
    .data_o(lat_d),
    .chk_o (lat_c)
  );

  assign use_lat = (mode_i == MODE_CORR);
  assign src_d   = use_lat ? lat_d : data_i;
  assign src_c   = use_lat ? lat_c : chk_i;
  assign word    = {src_c, src_d};
  assign gross   = (&word) | ~(|word);

  edac_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CHK_INV(CHK_INV)) u_gen (
    .data_i(src_d),
    .chk_o (gen_c)
  );

  assign syn = gen_c ^ src_c;

  edac_syn_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
    .syn_i  (syn),
    .gross_i(gross),
    .flip_o (flip),
    .sgl_o  (sgl),
    .mul_o  (mul)
  );

  always_comb begin
    d_nx = data_i;
    c_nx = gen_c;
    s_nx = 1'b0;
    m_nx = 1'b0;
    unique case (mode_i)
      MODE_WRITE: begin
        d_nx = data_i;
        c_nx = gen_c;
      end
      MODE_DIAG: begin
        d_nx = lat_d;
        c_nx = lat_c;
      end
      MODE_FLAG: begin
        d_nx = data_i;
        c_nx = syn;
        s_nx = sgl;
        m_nx = mul;
      end
      default: begin
        d_nx = lat_d ^ flip;
        c_nx = syn;
        s_nx = sgl;
        m_nx = mul;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      chk_o     <= '0;
      sgl_err_o <= 1'b0;
      mul_err_o <= 1'b0;
    end else begin
      data_o    <= d_nx;
      chk_o     <= c_nx;
      sgl_err_o <= s_nx;
      mul_err_o <= m_nx;
    end
  end

  a_r6_mul_has_sgl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_err_o |-> sgl_err_o);
  a_r2_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == MODE_WRITE) |-> (!sgl_err_o && !mul_err_o));
  a_r10_diag_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == MODE_DIAG) |-> (!sgl_err_o && !mul_err_o && data_o == $past(lat_d)));
  a_r4_single_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flip));
  a_r5_chk_err_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == MODE_CORR && $onehot($past(syn))) |-> data_o == $past(lat_d));
  a_r6_no_fix_on_mul: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == MODE_CORR && $past(mul)) |-> data_o == $past(lat_d));
endmodule

// File: tb/secded_edac_bench.sv
module secded_edac_bench;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [DW-1:0] din = '0;
  logic [CW-1:0] cin = '0;
  logic [DW-1:0] dout;
  logic [CW-1:0] cout;
  logic          sgl, mul;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  secded_edac u_secded_edac (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .data_i(din), .chk_i(cin),
    .data_o(dout), .chk_o(cout), .sgl_err_o(sgl), .mul_err_o(mul)
  );

  function automatic logic [CW-1:0] ref_col(input int j);
    int n = 0;
    logic [CW-1:0] r = '0;
    for (int v = 1; v < 128; v++) begin
      if ($countones(v) == 3) begin
        if (n == j) r = v[CW-1:0];
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] ref_gen(input logic [DW-1:0] d);
    logic [CW-1:0] c = 7'b0000011;
    for (int j = 0; j < DW; j++) begin
      logic [CW-1:0] col = ref_col(j);
      for (int i = 0; i < CW; i++) if (col[i]) c[i] = c[i] ^ d[j];
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [DW-1:0] d, input logic [CW-1:0] c);
    mode = m; din = d; cin = c;
    @(negedge clk);
  endtask

  // flag pass then correct pass on a word, junk inputs during correct
  task automatic read_word(input string tag, input logic [DW-1:0] d, input logic [CW-1:0] c);
    logic [CW-1:0] s;
    logic [DW-1:0] fix;
    logic xs, xm;
    logic [CW+DW-1:0] w;
    s = ref_gen(d) ^ c;
    w = {c, d};
    fix = d; xs = 1'b0; xm = 1'b0;
    if (&w || ~|w) begin xs = 1'b1; xm = 1'b1; end
    else if (s != 0) begin
      xs = 1'b1; xm = 1'b1;
      for (int j = 0; j < DW; j++) if (ref_col(j) == s) begin fix[j] = ~fix[j]; xm = 1'b0; end
      if ($countones(s) == 1) xm = 1'b0;
    end
    step(2'b10, d, c);
    check({tag, " R3 flag data/syn"}, {dout, 1'b0, cout}, {d, 1'b0, s});
    check({tag, " flag flags"}, {sgl, mul}, {xs, xm});
    step(2'b11, $urandom, $urandom);
    check({tag, " R9 corr data/syn"}, {dout, 1'b0, cout}, {fix, 1'b0, s});
    check({tag, " corr flags"}, {sgl, mul}, {xs, xm});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [CW-1:0] c;
    logic [CW+DW-1:0] w;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", {dout, cout, sgl, mul}, '0);
    rst_n = 1'b1;
    step(2'b01, 32'hffff_ffff, 7'h7f);
    check("R11 held regs after reset", {dout, 1'b0, cout, sgl, mul}, '0);

    // R1 R2 write mode, directed columns and random data
    step(2'b00, 32'h0000_0001, '0);
    check("R1 col0", {dout, 1'b0, cout, sgl, mul}, {32'h1, 1'b0, 7'b0000100, 2'b00});
    step(2'b00, 32'h8000_0000, '0);
    check("R1 col31", cout, 7'b1100010 ^ 7'b0000011);
    for (int k = 0; k < 20; k++) begin
      d = $urandom;
      step(2'b00, d, $urandom);
      check("R2 write", {dout, 1'b0, cout, sgl, mul}, {d, 1'b0, ref_gen(d), 2'b00});
    end

    // R8 clean words
    for (int k = 0; k < 10; k++) begin
      d = $urandom;
      read_word("R8 clean", d, ref_gen(d));
    end

    // R4 R5 every single-bit error
    for (int p = 0; p < DW + CW; p++) begin
      d = $urandom;
      w = {ref_gen(d), d};
      w[p] = ~w[p];
      read_word(p < DW ? "R4 data single" : "R5 check single", w[DW-1:0], w[CW+DW-1:DW]);
    end

    // R6 random double-bit errors
    for (int k = 0; k < 200; k++) begin
      int a, b;
      a = $urandom_range(DW + CW - 1);
      b = $urandom_range(DW + CW - 1);
      if (a == b) b = (a + 1) % (DW + CW);
      d = $urandom;
      w = {ref_gen(d), d};
      w[a] = ~w[a]; w[b] = ~w[b];
      read_word("R6 double", w[DW-1:0], w[CW+DW-1:DW]);
    end

    // R7 gross words
    read_word("R7 zeros", '0, '0);
    check("R7 zeros flags", {sgl, mul}, 2'b11);
    read_word("R7 ones", '1, '1);
    check("R7 ones flags", {sgl, mul}, 2'b11);

    // R9 R10 hold across other modes, diagnostic readback
    d = 32'hdead_beef;
    c = 7'h2a;
    step(2'b10, d, c);
    step(2'b00, $urandom, $urandom);
    step(2'b11, $urandom, $urandom);
    step(2'b01, $urandom, $urandom);
    check("R10 diag readback", {dout, 1'b0, cout}, {d, 1'b0, c});
    check("R10 diag flags", {sgl, mul}, 2'b00);
    step(2'b11, '0, '0);
    check("R9 corr ignores inputs syn", cout, ref_gen(d) ^ c);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule